// File: doc/BRIEF.md
# Memory Check-Byte Guard with Error Injection and Capture

This block sits between a memory controller's data path and the memory device on a 64-bit bus protected by an 8-bit single-error-correct, double-error-detect check byte. On the write side it computes the check byte for each word. Software can set it to corrupt stored data and check bits on purpose, so that the correction and reporting path can be exercised on real hardware. On the read-return side it checks every returned beat, corrects single-bit errors and flags uncorrectable ones. It also takes a memory-select error indication that comes from address decoding.

Reported errors set sticky detect flags, which software clears by writing ones to them. They raise an interrupt through per-class enables. They also load a set of capture registers (address, raw data, raw check byte and transaction attributes), but only when no capture is already held. Single-bit errors are counted by a saturating 8-bit counter, and they are reported only once the counter reaches a programmable threshold. Each error class can be disabled on its own.

All register fields sit on a simple word-addressed register bus with byte enables. Reads are combinational. Write and read-return paths are combinational, and all state changes on the rising clock edge.

Top module: `ecc_guard_top`

## Requirements
- R1: Check byte: data bit i is given the i-th integer, counting upward from 3, that is not a power of two. Check bits 6..0 are the XOR of the position values of all data bits that are one. Check bit 7 is the XOR of all 64 data bits and check bits 6..0. With injection and mirror off, `mem_wr_data` equals `wr_data` and `mem_wr_chk` is that code.
- R2: With the inject-enable bit (bit 8 of register 6) set, the stored data is `wr_data` XOR {register 4, register 5}, with register 4 covering bits 63..32. The stored check byte is the code XOR the mask in bits 7..0 of register 6. A write to register 6 with only byte enable 0 changes the mask and leaves bits 8 and 9 unchanged. With bit 8 clear, writes are stored clean.
- R3: With the mirror bit (bit 9 of register 6) set, the stored check byte is bits 7..0 of the stored data, including any data mask that is applied.
- R4: A returned beat with one flipped bit among its 72 bits comes back on `rdo_data` corrected, with `rdo_uncorr` low. A beat with two flipped bits comes back uncorrected, with `rdo_uncorr` high.
- R5: Register 0 holds the flags single-bit (bit 0), multi-bit (bit 1), memory-select (bit 2, raised by `rd_sel_err`) and multiple-errors (bit 3). The flags reset to zero, and writing a one to a bit clears it.
- R6: Register 1 bits 0, 1 and 2 disable the single-bit, multi-bit and memory-select classes. A disabled class sets no flag, loads no capture and does not count. Correction and `rdo_uncorr` are unaffected.
- R7: Bits 2..0 of register 2 enable the interrupt for the flags in the same bit order. `irq` is high exactly when an enabled flag is set.
- R8: Register 3 holds the single-bit error count (byte 0) and the threshold (byte 1). Each byte is written only under its own byte enable. Each enabled single-bit error increments the count, which saturates at 255.
- R9: A single-bit error sets flag bit 0 only if the incremented count is at least the threshold, so a threshold of 0 reports every one.
- R10: The first reported error while the capture valid bit is clear loads register 7 (address), 8 (raw data 63..32), 9 (raw data 31..0), 10 (raw check byte) and 11. Register 11 is {type, source, size, beat, valid} packed upward from bit 0. Later errors leave the capture unchanged.
- R11: A reported error that arrives while any of flags 2..0 is set also sets flag bit 3.
- R12: Any write to registers 7 to 11 clears that register to zero. Clearing register 11 clears the valid bit and re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_data | input | 64 | Write data from the controller |
| mem_wr_valid | output | 1 | Write beat to memory |
| mem_wr_data | output | 64 | Data stored in memory |
| mem_wr_chk | output | 8 | Check byte stored in memory |
| rd_valid | input | 1 | Returned read beat present |
| rd_addr | input | ADDR_W | Address of the returned beat |
| rd_data | input | 64 | Raw returned data |
| rd_chk | input | 8 | Raw returned check byte |
| rd_sel_err | input | 1 | Beat hit no memory select |
| rd_beat | input | BEAT_W | Beat number within the burst |
| rd_size | input | SIZE_W | Transaction size code |
| rd_src | input | SRC_W | Transaction source id |
| rd_type | input | TYPE_W | Transaction type code |
| rdo_valid | output | 1 | Checked beat present |
| rdo_data | output | 64 | Corrected read data |
| rdo_uncorr | output | 1 | Beat holds an uncorrectable error |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_be | input | 4 | Register write byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit address, attribute fields of 3, 2, 5 and 2 bits, and the injection logic present. This puts every capture attribute bit and every injection control within reach. Random words with one or two flips placed anywhere in the 72 bits cover every syndrome class. Those random reads run with all classes disabled, so they also show that disables leave no trace. Directed sequences then drive the threshold count, saturation at 255, first-error capture, the multiple-error flag and per-register capture clears.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

   localparam int unsigned WORD_W = 64;
   localparam int unsigned CODE_W = 8;
   localparam int unsigned SYN_W  = 7;

   // register word addresses
   localparam logic [3:0] RA_DETECT = 4'd0;
   localparam logic [3:0] RA_DISABLE = 4'd1;
   localparam logic [3:0] RA_IRQEN  = 4'd2;
   localparam logic [3:0] RA_SBE    = 4'd3;
   localparam logic [3:0] RA_INJ_HI = 4'd4;
   localparam logic [3:0] RA_INJ_LO = 4'd5;
   localparam logic [3:0] RA_INJ_CT = 4'd6;
   localparam logic [3:0] RA_CAP_AD = 4'd7;
   localparam logic [3:0] RA_CAP_HI = 4'd8;
   localparam logic [3:0] RA_CAP_LO = 4'd9;
   localparam logic [3:0] RA_CAP_CK = 4'd10;
   localparam logic [3:0] RA_CAP_AT = 4'd11;

   // codeword position given to data bit idx (skips powers of two)
   function automatic int unsigned data_pos(input int unsigned idx);
      int unsigned n;
      int unsigned r;
      n = 0;
      r = 0;
      for (int unsigned q = 3; q < 128; q++) begin
         if ((q & (q - 1)) != 0) begin
            if (n == idx) r = q;
            n++;
         end
      end
      return r;
   endfunction

   // data bits that feed check bit j
   function automatic logic [WORD_W-1:0] code_mask(input int unsigned j);
      logic [WORD_W-1:0] m;
      int unsigned p;
      m = '0;
      for (int unsigned i = 0; i < WORD_W; i++) begin
         p = data_pos(i);
         m[i] = p[j];
      end
      return m;
   endfunction

   function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
      return r;
   endfunction

endpackage

// File: rtl/ecc_guard_enc.sv
module ecc_guard_enc import ecc_guard_pkg::*; #(
   parameter int unsigned DATA_W = WORD_W,
   parameter int unsigned CHK_W  = CODE_W
)(
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   localparam int unsigned LOW_W = CHK_W - 1;

   if (DATA_W != 64 || CHK_W != 8) begin : g_bad_width
      $error("ecc_guard_enc supports a 64-bit word with an 8-bit code only");
   end

   logic [LOW_W-1:0] low;

   for (genvar j = 0; j < LOW_W; j++) begin : g_bit
      localparam logic [DATA_W-1:0] MASK = code_mask(j);
      assign low[j] = ^(data & MASK);
   end

   assign chk = {(^data) ^ (^low), low};
endmodule

// File: rtl/ecc_guard_dec.sv
module ecc_guard_dec import ecc_guard_pkg::*; #(
   parameter int unsigned DATA_W = WORD_W,
   parameter int unsigned CHK_W  = CODE_W
)(
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [DATA_W-1:0] data_fix,
   output logic              single,
   output logic              multi
);
   localparam int unsigned LOW_W = CHK_W - 1;

   logic [CHK_W-1:0] regen;
   logic [LOW_W-1:0] syn;
   logic             par_bad;

   ecc_guard_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_regen (
      .data (data),
      .chk  (regen)
   );

   assign syn     = regen[LOW_W-1:0] ^ chk[LOW_W-1:0];
   assign par_bad = (^data) ^ (^chk);
   assign single  = par_bad;
   assign multi   = !par_bad && (syn != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int unsigned POS = data_pos(i);
      assign data_fix[i] = data[i] ^ (single && (syn == POS[LOW_W-1:0]));
   end
endmodule

// File: rtl/ecc_guard_inj.sv
module ecc_guard_inj import ecc_guard_pkg::*; #(
   parameter int unsigned DATA_W = WORD_W,
   parameter int unsigned CHK_W  = CODE_W
)(
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] data_mask,
   input  logic [CHK_W-1:0]  chk_mask,
   input  logic              inj_on,
   input  logic              mirror,
   output logic [DATA_W-1:0] st_data,
   output logic [CHK_W-1:0]  st_chk
);
   logic [CHK_W-1:0] code;

   ecc_guard_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data (wr_data),
      .chk  (code)
   );

   assign st_data = inj_on ? (wr_data ^ data_mask) : wr_data;

   always_comb begin
      st_chk = inj_on ? (code ^ chk_mask) : code;
      if (mirror) st_chk = st_data[CHK_W-1:0];
   end
endmodule

// File: rtl/ecc_guard_top.sv
module ecc_guard_top import ecc_guard_pkg::*; #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BEAT_W    = 3,
   parameter int unsigned SIZE_W    = 2,
   parameter int unsigned SRC_W     = 5,
   parameter int unsigned TYPE_W    = 2,
   parameter bit          INJECT_EN = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [63:0]        wr_data,
   output logic               mem_wr_valid,
   output logic [63:0]        mem_wr_data,
   output logic [7:0]         mem_wr_chk,
   input  logic               rd_valid,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [63:0]        rd_data,
   input  logic [7:0]         rd_chk,
   input  logic               rd_sel_err,
   input  logic [BEAT_W-1:0]  rd_beat,
   input  logic [SIZE_W-1:0]  rd_size,
   input  logic [SRC_W-1:0]   rd_src,
   input  logic [TYPE_W-1:0]  rd_type,
   output logic               rdo_valid,
   output logic [63:0]        rdo_data,
   output logic               rdo_uncorr,
   input  logic               reg_we,
   input  logic [3:0]         reg_addr,
   input  logic [3:0]         reg_be,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq
);
   localparam int unsigned ATTR_W = TYPE_W + SRC_W + SIZE_W + BEAT_W;
   localparam int unsigned HALF_W = WORD_W / 2;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 1..32");
   end
   if (ATTR_W + 1 > 32) begin : g_bad_attr
      $error("attribute fields plus valid bit must fit in 32 bits");
   end
   if (BEAT_W < 1 || SIZE_W < 1 || SRC_W < 1 || TYPE_W < 1) begin : g_bad_field
      $error("attribute fields must be at least one bit wide");
   end

   // ---------------- register state ----------------
   logic [3:0]          det;
   logic [2:0]          dis;
   logic [2:0]          ien;
   logic [7:0]          sbe_cnt, sbe_thr;
   logic [31:0]         inj_hi, inj_lo;
   logic [7:0]          inj_mask;
   logic                inj_on, inj_mirror;
   logic [ADDR_W-1:0]   cap_addr;
   logic [HALF_W-1:0]   cap_hi, cap_lo;
   logic [7:0]          cap_chk;
   logic [ATTR_W-1:0]   cap_attr;
   logic                cap_valid;

   // ---------------- write path ----------------
   logic [WORD_W-1:0] st_data;
   logic [CODE_W-1:0] st_chk;

   if (INJECT_EN) begin : g_inj
      ecc_guard_inj u_inj (
         .wr_data   (wr_data),
         .data_mask ({inj_hi, inj_lo}),
         .chk_mask  (inj_mask),
         .inj_on    (inj_on),
         .mirror    (inj_mirror),
         .st_data   (st_data),
         .st_chk    (st_chk)
      );
   end else begin : g_plain
      ecc_guard_enc u_enc (
         .data (wr_data),
         .chk  (st_chk)
      );
      assign st_data = wr_data;
   end

   assign mem_wr_valid = wr_valid;
   assign mem_wr_data  = st_data;
   assign mem_wr_chk   = st_chk;

   // ---------------- read path ----------------
   logic [WORD_W-1:0] fix_data;
   logic              dec_single, dec_multi;

   ecc_guard_dec u_dec (
      .data     (rd_data),
      .chk      (rd_chk),
      .data_fix (fix_data),
      .single   (dec_single),
      .multi    (dec_multi)
   );

   assign rdo_valid  = rd_valid;
   assign rdo_data   = fix_data;
   assign rdo_uncorr = rd_valid && dec_multi;

   // ---------------- event qualification ----------------
   logic       ev_sbe, ev_mbe, ev_mse;
   logic       sbe_go, sbe_rep, mbe_rep, mse_rep, any_rep, pend, cap_take;
   logic [7:0] cnt_inc;

   assign ev_sbe  = rd_valid && !rd_sel_err && dec_single;
   assign ev_mbe  = rd_valid && !rd_sel_err && dec_multi;
   assign ev_mse  = rd_valid && rd_sel_err;

   assign cnt_inc = (sbe_cnt == 8'hFF) ? sbe_cnt : sbe_cnt + 8'd1;
   assign sbe_go  = ev_sbe && !dis[0];
   assign sbe_rep = sbe_go && (cnt_inc >= sbe_thr);
   assign mbe_rep = ev_mbe && !dis[1];
   assign mse_rep = ev_mse && !dis[2];
   assign any_rep = sbe_rep || mbe_rep || mse_rep;
   assign pend    = |det[2:0];
   assign cap_take = any_rep && !cap_valid;

   // ---------------- register bus decode ----------------
   logic w_det, w_dis, w_ien, w_sbe, w_hi, w_lo, w_ct;
   logic w_cad, w_chi, w_clo, w_cck, w_cat;
   logic [3:0] det_clr, det_set;

   assign w_det = reg_we && (reg_addr == RA_DETECT);
   assign w_dis = reg_we && (reg_addr == RA_DISABLE);
   assign w_ien = reg_we && (reg_addr == RA_IRQEN);
   assign w_sbe = reg_we && (reg_addr == RA_SBE);
   assign w_hi  = reg_we && (reg_addr == RA_INJ_HI);
   assign w_lo  = reg_we && (reg_addr == RA_INJ_LO);
   assign w_ct  = reg_we && (reg_addr == RA_INJ_CT);
   assign w_cad = reg_we && (reg_addr == RA_CAP_AD);
   assign w_chi = reg_we && (reg_addr == RA_CAP_HI);
   assign w_clo = reg_we && (reg_addr == RA_CAP_LO);
   assign w_cck = reg_we && (reg_addr == RA_CAP_CK);
   assign w_cat = reg_we && (reg_addr == RA_CAP_AT);

   assign det_clr = (w_det && reg_be[0]) ? reg_wdata[3:0] : 4'h0;
   assign det_set = {any_rep && pend, mse_rep, mbe_rep, sbe_rep};

   // configuration and flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det        <= '0;
         dis        <= '0;
         ien        <= '0;
         sbe_cnt    <= '0;
         sbe_thr    <= '0;
         inj_hi     <= '0;
         inj_lo     <= '0;
         inj_mask   <= '0;
         inj_on     <= 1'b0;
         inj_mirror <= 1'b0;
      end else begin
         det <= (det & ~det_clr) | det_set;
         if (w_dis && reg_be[0]) dis <= reg_wdata[2:0];
         if (w_ien && reg_be[0]) ien <= reg_wdata[2:0];
         if (w_sbe && reg_be[0])  sbe_cnt <= reg_wdata[7:0];
         else if (sbe_go)         sbe_cnt <= cnt_inc;
         if (w_sbe && reg_be[1])  sbe_thr <= reg_wdata[15:8];
         if (w_hi) inj_hi <= merge_bytes(inj_hi, reg_wdata, reg_be);
         if (w_lo) inj_lo <= merge_bytes(inj_lo, reg_wdata, reg_be);
         if (w_ct && reg_be[0]) inj_mask <= reg_wdata[7:0];
         if (w_ct && reg_be[1]) begin
            inj_on     <= reg_wdata[8];
            inj_mirror <= reg_wdata[9];
         end
      end
   end

   // first-error capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr  <= '0;
         cap_hi    <= '0;
         cap_lo    <= '0;
         cap_chk   <= '0;
         cap_attr  <= '0;
         cap_valid <= 1'b0;
      end else begin
         if (w_cad) cap_addr <= '0;
         if (w_chi) cap_hi   <= '0;
         if (w_clo) cap_lo   <= '0;
         if (w_cck) cap_chk  <= '0;
         if (w_cat) begin
            cap_attr  <= '0;
            cap_valid <= 1'b0;
         end
         if (cap_take) begin
            cap_addr  <= rd_addr;
            cap_hi    <= rd_data[WORD_W-1:HALF_W];
            cap_lo    <= rd_data[HALF_W-1:0];
            cap_chk   <= rd_chk;
            cap_attr  <= {rd_type, rd_src, rd_size, rd_beat};
            cap_valid <= 1'b1;
         end
      end
   end

   assign irq = |(det[2:0] & ien);

   // ---------------- register read ----------------
   logic [31:0] cap_addr_w, cap_attr_w;

   always_comb begin
      cap_addr_w = '0;
      cap_addr_w[ADDR_W-1:0] = cap_addr;
      cap_attr_w = '0;
      cap_attr_w[ATTR_W:0] = {cap_attr, cap_valid};
   end

   always_comb begin
      case (reg_addr)
         RA_DETECT:  reg_rdata = {28'd0, det};
         RA_DISABLE: reg_rdata = {29'd0, dis};
         RA_IRQEN:   reg_rdata = {29'd0, ien};
         RA_SBE:     reg_rdata = {16'd0, sbe_thr, sbe_cnt};
         RA_INJ_HI:  reg_rdata = inj_hi;
         RA_INJ_LO:  reg_rdata = inj_lo;
         RA_INJ_CT:  reg_rdata = {22'd0, inj_mirror, inj_on, inj_mask};
         RA_CAP_AD:  reg_rdata = cap_addr_w;
         RA_CAP_HI:  reg_rdata = cap_hi;
         RA_CAP_LO:  reg_rdata = cap_lo;
         RA_CAP_CK:  reg_rdata = {24'd0, cap_chk};
         RA_CAP_AT:  reg_rdata = cap_attr_w;
         default:    reg_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk import ecc_guard_pkg::*; #(
   parameter int unsigned ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rdo_valid,
   input logic              rdo_uncorr,
   input logic [3:0]        det,
   input logic [2:0]        dis,
   input logic [2:0]        ien,
   input logic              irq,
   input logic [7:0]        sbe_cnt,
   input logic              cap_valid,
   input logic [ADDR_W-1:0] cap_addr,
   input logic              reg_we,
   input logic [3:0]        reg_addr,
   input logic [3:0]        reg_be,
   input logic [31:0]       reg_wdata,
   input logic              ev_mbe
);
   // R4: an uncorrectable mark only accompanies a returned beat
   p_uncorr_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdo_uncorr |-> rdo_valid);

   // R5: writing one to the multi-bit flag clears it when no new one arrives
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_DETECT && reg_be[0] && reg_wdata[1] && !ev_mbe)
      |=> !det[1]);

   // R6: a disabled single-bit class never raises its flag
   p_dis_sbe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis[0] |=> !$rose(det[0]));

   // R7: no interrupt without any enable
   p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 3'b000) |-> !irq);

   // R8: counter stays saturated unless software rewrites it
   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_cnt == 8'hFF && !(reg_we && reg_addr == RA_SBE && reg_be[0]))
      |=> sbe_cnt == 8'hFF);

   // R10: a held capture is not overwritten
   p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !reg_we) |=> (cap_valid && $stable(cap_addr)));

   // R11: the multiple-errors flag rises only over a pending flag
   p_multi_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det[3]) |-> ($past(det[2:0]) != 3'b000));
endmodule

bind ecc_guard_top ecc_guard_chk #(.ADDR_W(ADDR_W)) u_ecc_guard_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rdo_valid  (rdo_valid),
   .rdo_uncorr (rdo_uncorr),
   .det        (det),
   .dis        (dis),
   .ien        (ien),
   .irq        (irq),
   .sbe_cnt    (sbe_cnt),
   .cap_valid  (cap_valid),
   .cap_addr   (cap_addr),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_be     (reg_be),
   .reg_wdata  (reg_wdata),
   .ev_mbe     (ev_mbe)
);

// File: tb/ecc_guard_top_bench.sv
module ecc_guard_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [63:0] wr_data = '0;
   logic        mem_wr_valid;
   logic [63:0] mem_wr_data;
   logic [7:0]  mem_wr_chk;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_addr = '0;
   logic [63:0] rd_data = '0;
   logic [7:0]  rd_chk = '0;
   logic        rd_sel_err = 1'b0;
   logic [2:0]  rd_beat = '0;
   logic [1:0]  rd_size = '0;
   logic [4:0]  rd_src = '0;
   logic [1:0]  rd_type = '0;
   logic        rdo_valid;
   logic [63:0] rdo_data;
   logic        rdo_uncorr;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [63:0] got_data;
   logic        got_unc;
   logic [63:0] got_wd;
   logic [7:0]  got_wc;

   always #4 clk = ~clk;

   ecc_guard_top u_ecc_guard_top (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data), .mem_wr_chk(mem_wr_chk),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_chk(rd_chk),
      .rd_sel_err(rd_sel_err), .rd_beat(rd_beat), .rd_size(rd_size),
      .rd_src(rd_src), .rd_type(rd_type),
      .rdo_valid(rdo_valid), .rdo_data(rdo_data), .rdo_uncorr(rdo_uncorr),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // reference code: XOR of positions of set data bits, plus overall parity
   function automatic logic [7:0] ref_code(input logic [63:0] d);
      logic [7:0] c;
      int n;
      c = '0;
      n = 0;
      for (int p = 3; n < 64; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[n]) c[6:0] = c[6:0] ^ p[6:0];
            n++;
         end
      end
      c[7] = (^d) ^ (^c[6:0]);
      return c;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_be = '0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_beat_go(input logic [31:0] a, input logic [63:0] d, input logic [7:0] c,
                             input logic sel, input logic [2:0] bt, input logic [1:0] sz,
                             input logic [4:0] src, input logic [1:0] ty);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_chk = c; rd_sel_err = sel;
      rd_beat = bt; rd_size = sz; rd_src = src; rd_type = ty;
      #1;
      got_data = rdo_data;
      got_unc  = rdo_uncorr;
      @(negedge clk);
      rd_valid = 1'b0; rd_sel_err = 1'b0;
   endtask

   // one or two flipped bits in a valid codeword
   task automatic rd_flipped(input logic [31:0] a, input logic [63:0] d, input int k1, input int k2);
      logic [71:0] w;
      w = {ref_code(d), d};
      w[k1] = ~w[k1];
      if (k2 >= 0) w[k2] = ~w[k2];
      rd_beat_go(a, w[63:0], w[71:64], 1'b0, 3'd0, 2'd0, 5'd0, 2'd0);
   endtask

   task automatic wr_probe(input logic [63:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      #1;
      got_wd = mem_wr_data;
      got_wc = mem_wr_chk;
      wr_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] r;
      logic [63:0] d, m;
      logic [7:0]  cm;
      logic [71:0] w;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      reg_read(4'd0, r);  check("R5 detect after reset", r, 0);
      reg_read(4'd3, r);  check("R8 counter after reset", r, 0);
      reg_read(4'd11, r); check("R10 capture attr after reset", r, 0);
      check("R7 irq after reset", irq, 0);

      // clean writes
      for (int i = 0; i < 20; i++) begin
         d = {$urandom, $urandom};
         wr_probe(d);
         check("R1 clean data", got_wd, d);
         check("R1 clean code", got_wc, ref_code(d));
      end
      wr_probe(64'd0);
      check("R1 zero word code", got_wc, 8'h00);

      // random single and double flips with every class disabled
      reg_write(4'd1, 4'h1, 32'h7);
      for (int i = 0; i < 40; i++) begin
         d = {$urandom, $urandom};
         rd_flipped($urandom, d, $urandom_range(71, 0), -1);
         check("R4 single corrected data", got_data, d);
         check("R4 single not uncorrectable", got_unc, 0);
      end
      for (int i = 0; i < 40; i++) begin
         int k1, k2;
         d = {$urandom, $urandom};
         k1 = $urandom_range(71, 0);
         k2 = (k1 + 1 + $urandom_range(70, 0)) % 72;
         w = {ref_code(d), d};
         w[k1] = ~w[k1];
         w[k2] = ~w[k2];
         rd_flipped(32'h40, d, k1, k2);
         check("R4 double passed raw", got_data, w[63:0]);
         check("R4 double marked", got_unc, 1);
      end
      rd_beat_go(32'h80, 64'd5, 8'd0, 1'b1, 3'd0, 2'd0, 5'd0, 2'd0);
      reg_read(4'd0, r);  check("R6 no flags while disabled", r, 0);
      reg_read(4'd3, r);  check("R6 no count while disabled", r, 0);
      reg_read(4'd11, r); check("R6 no capture while disabled", r, 0);
      reg_write(4'd1, 4'h1, 32'h0);

      d = {$urandom, $urandom};
      rd_beat_go(32'h88, d, ref_code(d), 1'b0, 3'd0, 2'd0, 5'd0, 2'd0);
      check("R4 clean read data", got_data, d);
      reg_read(4'd0, r); check("R4 clean read no flag", r, 0);

      // injection
      m  = {$urandom, $urandom};
      cm = 8'h5A;
      reg_write(4'd4, 4'hF, m[63:32]);
      reg_write(4'd5, 4'hF, m[31:0]);
      reg_write(4'd6, 4'h3, {22'd0, 1'b0, 1'b1, cm});
      d = {$urandom, $urandom};
      wr_probe(d);
      check("R2 injected data", got_wd, d ^ m);
      check("R2 injected code", got_wc, ref_code(d) ^ cm);
      reg_write(4'd6, 4'h1, 32'h0000_03C3);
      reg_read(4'd6, r);
      check("R2 mask write keeps controls", r, 32'h0000_01C3);
      reg_write(4'd6, 4'h2, 32'h0);
      wr_probe(d);
      check("R2 disabled data clean", got_wd, d);
      check("R2 disabled code clean", got_wc, ref_code(d));

      // mirror
      reg_write(4'd6, 4'h2, 32'h0000_0300);
      wr_probe(d);
      check("R3 mirror with mask", got_wc, (d ^ m) & 64'hFF);
      reg_write(4'd6, 4'h2, 32'h0000_0200);
      wr_probe(d);
      check("R3 mirror clean data", got_wc, d[7:0]);
      reg_write(4'd6, 4'h3, 32'h0);

      // threshold of three
      reg_write(4'd3, 4'h3, 32'h0000_0300);
      d = 64'h0123_4567_89AB_CDEF;
      rd_flipped(32'h100, d, 5, -1);
      reg_read(4'd0, r); check("R9 below threshold first", r, 0);
      rd_flipped(32'h108, d, 70, -1);
      reg_read(4'd3, r); check("R8 count two", r, 32'h0302);
      reg_read(4'd0, r); check("R9 below threshold second", r, 0);
      w = {ref_code(d), d};
      w[40] = ~w[40];
      rd_beat_go(32'h1A40, w[63:0], w[71:64], 1'b0, 3'd5, 2'd2, 5'd9, 2'd1);
      check("R4 directed correction", got_data, d);
      reg_read(4'd0, r); check("R9 at threshold", r, 1);
      reg_read(4'd7, r); check("R10 capture address", r, 32'h1A40);
      reg_read(4'd8, r); check("R10 capture high", r, w[63:32]);
      reg_read(4'd9, r); check("R10 capture low", r, w[31:0]);
      reg_read(4'd10, r); check("R10 capture code", r, w[71:64]);
      reg_read(4'd11, r); check("R10 capture attributes", r, {19'd0, 2'd1, 5'd9, 2'd2, 3'd5, 1'b1});

      // interrupt
      check("R7 irq masked", irq, 0);
      reg_write(4'd2, 4'h1, 32'h1);
      check("R7 irq enabled", irq, 1);
      reg_write(4'd2, 4'h1, 32'h2);
      check("R7 irq other class only", irq, 0);

      // second error while pending
      rd_flipped(32'h2000, d, 3, 9);
      reg_read(4'd0, r); check("R11 multi flag set", r, 32'hB);
      reg_read(4'd7, r); check("R10 capture kept", r, 32'h1A40);
      check("R7 irq for multi-bit", irq, 1);

      // write-one-to-clear
      reg_write(4'd0, 4'h1, 32'hF);
      reg_read(4'd0, r); check("R5 flags cleared", r, 0);
      check("R7 irq after clear", irq, 0);

      // memory select
      rd_beat_go(32'h3000, 64'd0, 8'd0, 1'b1, 3'd0, 2'd0, 5'd0, 2'd0);
      reg_read(4'd0, r); check("R5 select flag", r, 32'h4);
      reg_read(4'd7, r); check("R10 select keeps capture", r, 32'h1A40);

      // capture clears
      reg_write(4'd11, 4'hF, 32'hFFFF_FFFF);
      reg_read(4'd11, r); check("R12 attr cleared", r, 0);
      reg_read(4'd7, r);  check("R12 address kept until its write", r, 32'h1A40);
      reg_write(4'd7, 4'hF, 32'h1);
      reg_write(4'd8, 4'hF, 32'h1);
      reg_write(4'd9, 4'hF, 32'h1);
      reg_write(4'd10, 4'hF, 32'h1);
      reg_read(4'd7, r);  check("R12 address cleared", r, 0);
      reg_read(4'd8, r);  check("R12 high cleared", r, 0);
      reg_read(4'd9, r);  check("R12 low cleared", r, 0);
      reg_read(4'd10, r); check("R12 code cleared", r, 0);
      reg_write(4'd0, 4'h1, 32'hF);
      rd_flipped(32'h4440, d, 0, 1);
      reg_read(4'd7, r); check("R12 capture re-armed", r, 32'h4440);
      reg_read(4'd0, r); check("R11 no multi without pending", r, 32'h2);
      reg_write(4'd0, 4'h1, 32'hF);

      // saturation and byte lanes
      reg_write(4'd3, 4'h3, 32'h0000_FFFE);
      rd_flipped(32'h500, d, 12, -1);
      reg_read(4'd3, r); check("R8 reach 255", r, 32'hFFFF);
      reg_read(4'd0, r); check("R9 threshold 255", r, 1);
      rd_flipped(32'h508, d, 13, -1);
      reg_read(4'd3, r); check("R8 saturated", r, 32'hFFFF);
      reg_write(4'd3, 4'h2, 32'h0000_1000);
      reg_read(4'd3, r); check("R8 threshold lane only", r, 32'h10FF);

      // threshold zero
      reg_write(4'd0, 4'h1, 32'hF);
      reg_write(4'd3, 4'h3, 32'h0);
      rd_flipped(32'h600, d, 64, -1);
      reg_read(4'd0, r); check("R9 threshold zero", r, 1);
      reg_read(4'd3, r); check("R8 count one", r, 1);

      // multi-bit disabled
      reg_write(4'd0, 4'h1, 32'hF);
      reg_write(4'd1, 4'h1, 32'h2);
      rd_flipped(32'h700, d, 20, 30);
      check("R6 still marked when disabled", got_unc, 1);
      reg_read(4'd0, r); check("R6 disabled multi-bit no flag", r, 0);

      finish_run();
   end
endmodule